// File: doc/BRIEF.md
# SPI Serial EEPROM Target

This block is a synthesizable SPI slave that answers like a small serial EEPROM. Its storage is an internal byte array. It works in SPI mode 0: data is sampled on the rising serial clock and shifted out on the falling edge. Every SPI input is resynchronised into the system clock domain. The serial clock half period must therefore last at least four system clocks.

A transaction starts when the select goes low. The first byte is the instruction. For reads and writes, an address follows. The parameter `ADDR_BYTES` sets its length to 1, 2 or 3 bytes, sent most significant byte first. When `NINE_BIT` is set, a single address byte follows and address bit 8 travels in instruction bit 3.

Written bytes are staged in a page buffer and are committed to the array when the select is released. A status busy flag then stays set for `WRITE_CYCLES` system clocks. While that flag is set, every instruction except a status read is ignored. The array size is `128 << SIZE_EXP` bytes and the page size is `8 << PAGE_EXP` bytes.

Top module: `spi_eeprom_target`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF. While the select is high, `spiDout` is 0.
- R2: Instruction codes are 0x01 status write, 0x02 write, 0x03 read, 0x04 latch clear, 0x05 status read and 0x06 latch set. In 9-bit mode, instruction bit 3 is masked before matching. Any other code leaves the status and the array unchanged.
- R3: The status byte layout is bit 0 busy, bit 1 write-enable latch, bits 2 and 3 block-protect, bit 7 protect-enable, and all other bits 0. Code 0x06 sets bit 1 and code 0x04 clears it. After code 0x05, every further byte clocked in the same transaction returns the current status byte on `spiDout`, most significant bit first.
- R4: In 9-bit mode, address bit 8 is taken from instruction bit 3 and one address byte follows. The two 256-byte halves of the array are addressed separately.
- R5: A read returns consecutive bytes from the given address. The address increments across the whole array and wraps from the last byte to byte 0.
- R6: Staged write data commits only when the select rises with the latch set and at least one complete data byte received. A trailing partial byte is dropped. A write with no data byte starts no write cycle and leaves the latch set.
- R7: During a write, the address increments only within its page. Bytes past the page end wrap to the page start, and a later byte to the same location overwrites an earlier one.
- R8: A commit sets the busy bit for exactly `WRITE_CYCLES` system clocks and clears the latch.
- R9: While busy, every instruction except 0x05 is ignored.
- R10: Code 0x01 with the latch set stores bits 7, 3 and 2 of its first data byte into the status byte and starts a write cycle. With the latch clear it has no effect.
- R11: A write sent while the latch is clear leaves the array unchanged and starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiClk | input | 1 | Serial clock from the master, idle low |
| spiSelN | input | 1 | Active-low device select |
| spiDin | input | 1 | Serial data from the master |
| spiDout | output | 1 | Serial data to the master, 0 while deselected |

## Verification
The assertions rely on two properties of the master:
- The serial clock is low whenever the select changes.
- No byte completes in the same system clock as a deselect.

Without these, a commit could coincide with a staged byte. The bench toggles the select only after a full half period with the clock held low. It keeps every half period at six system clocks, so each synchronised edge lands well clear of the previous one.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  // status bits that a status write may change (protect enable, two block protect)
  localparam logic [7:0] STAT_WR_MASK = 8'h8C;

  typedef enum logic [2:0] {
    C_OP, C_ADDR, C_READ, C_WRITE, C_STAT, C_WSTAT, C_SKIP
  } ctrlState_t;

  // strobes from control to datapath, each valid for one system clock
  typedef struct packed {
    logic addrStart;   // new read/write: clear address, load 9th bit
    logic addrShift;   // shift in one address byte
    logic readStep;    // advance read address across the array
    logic stageData;   // stage one write byte, advance inside the page
    logic stageStat;   // stage one status byte
    logic latchSet;
    logic latchClr;
    logic commitArr;   // copy staged page bytes into the array
    logic commitStat;  // copy staged status bits
    logic showStat;    // transmit status instead of array data
  } strobe_t;

endpackage

// File: rtl/spi_eeprom_shifter.sv
module spi_eeprom_shifter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiClk,
  input  logic       spiSelN,
  input  logic       spiDin,
  input  logic [7:0] txByte,
  output logic       selActive,
  output logic       selEnd,
  output logic       byteValid,
  output logic [7:0] rxByte,
  output logic       spiDout
);

  logic [SYNC_STAGES-1:0] clkSync, selSync, dinSync;
  logic clkPrev, selPrev;
  logic clkS, dinS, rise, fall;
  logic [2:0] bitCnt;
  logic [6:0] rxSh;
  logic [7:0] txSh;
  logic doutR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      selSync <= '1;
      dinSync <= '0;
      clkPrev <= 1'b0;
      selPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], spiClk};
      selSync <= {selSync[SYNC_STAGES-2:0], spiSelN};
      dinSync <= {dinSync[SYNC_STAGES-2:0], spiDin};
      clkPrev <= clkS;
      selPrev <= selActive;
    end
  end

  assign clkS      = clkSync[SYNC_STAGES-1];
  assign dinS      = dinSync[SYNC_STAGES-1];
  assign selActive = ~selSync[SYNC_STAGES-1];
  assign selEnd    = selPrev & ~selActive;
  assign rise      = selActive & clkS & ~clkPrev;
  assign fall      = selActive & ~clkS & clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxSh      <= '0;
      txSh      <= '0;
      doutR     <= 1'b0;
      byteValid <= 1'b0;
      rxByte    <= '0;
    end else if (!selActive) begin
      bitCnt    <= '0;
      rxSh      <= '0;
      txSh      <= '0;
      doutR     <= 1'b0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= rise && (bitCnt == 3'd7);
      if (rise) begin
        rxSh   <= {rxSh[5:0], dinS};
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) rxByte <= {rxSh, dinS};
      end
      if (fall) begin
        if (bitCnt == 3'd0) begin
          doutR <= txByte[7];
          txSh  <= {txByte[6:0], 1'b0};
        end else begin
          doutR <= txSh[7];
          txSh  <= {txSh[6:0], 1'b0};
        end
      end
    end
  end

  assign spiDout = doutR;

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_BYTES = 1,
  parameter bit NINE_BIT   = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] rxByte,
  input  logic       selEnd,
  input  logic       wip,
  input  logic       wel,
  output strobe_t    strb
);

  localparam logic [1:0] LEFT_INIT = NINE_BIT ? 2'd1 : 2'(ADDR_BYTES);

  ctrlState_t state, nextState;
  logic [1:0] addrLeft, nextLeft;
  logic isWrite, nextIsWrite;
  logic gotData, nextGot;
  logic [7:0] opMasked;

  assign opMasked = NINE_BIT ? (rxByte & 8'hF7) : rxByte;

  always_comb begin
    strb        = '0;
    nextState   = state;
    nextLeft    = addrLeft;
    nextIsWrite = isWrite;
    nextGot     = gotData;
    strb.showStat = (state == C_STAT);
    if (selEnd) begin
      strb.commitArr  = (state == C_WRITE) && gotData;
      strb.commitStat = (state == C_WSTAT) && gotData;
      nextState = C_OP;
      nextGot   = 1'b0;
    end else if (byteValid) begin
      unique case (state)
        C_OP: begin
          if (wip && opMasked != OP_RDSR) begin
            nextState = C_SKIP;
          end else begin
            unique case (opMasked)
              OP_WREN: begin strb.latchSet = 1'b1; nextState = C_SKIP; end
              OP_WRDI: begin strb.latchClr = 1'b1; nextState = C_SKIP; end
              OP_RDSR: nextState = C_STAT;
              OP_WRSR: nextState = C_WSTAT;
              OP_READ, OP_WRITE: begin
                strb.addrStart = 1'b1;
                nextLeft       = LEFT_INIT;
                nextIsWrite    = (opMasked == OP_WRITE);
                nextState      = C_ADDR;
              end
              default: nextState = C_SKIP;
            endcase
          end
        end
        C_ADDR: begin
          strb.addrShift = 1'b1;
          if (addrLeft == 2'd1) nextState = isWrite ? C_WRITE : C_READ;
          else nextLeft = addrLeft - 2'd1;
        end
        C_READ: strb.readStep = 1'b1;
        C_WRITE: begin
          if (wel) begin
            strb.stageData = 1'b1;
            nextGot        = 1'b1;
          end
        end
        C_WSTAT: begin
          if (wel && !gotData) begin
            strb.stageStat = 1'b1;
            nextGot        = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= C_OP;
      addrLeft <= '0;
      isWrite  <= 1'b0;
      gotData  <= 1'b0;
    end else begin
      state    <= nextState;
      addrLeft <= nextLeft;
      isWrite  <= nextIsWrite;
      gotData  <= nextGot;
    end
  end

endmodule

// File: rtl/spi_eeprom_dp.sv
module spi_eeprom_dp
  import spi_eeprom_pkg::*;
#(
  parameter int SIZE_EXP     = 2,
  parameter int PAGE_EXP     = 1,
  parameter bit NINE_BIT     = 1'b1,
  parameter int WRITE_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic [7:0] rxByte,
  output logic [7:0] txByte,
  output logic       wip,
  output logic       wel
);

  localparam int MEM_BYTES  = 128 << SIZE_EXP;
  localparam int ADDR_W     = 7 + SIZE_EXP;
  localparam int PAGE_BYTES = 8 << PAGE_EXP;
  localparam int PAGE_W     = 3 + PAGE_EXP;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [ADDR_W-1:0] addrReg, readNext, writeNext;
  logic [PAGE_W-1:0] pageOff;
  logic [7:0] statHold, statStage, statusByte;
  logic [CNT_W-1:0] busyCnt;
  logic welR;
  logic commitAny;

  assign pageOff   = addrReg[PAGE_W-1:0];
  assign readNext  = addrReg + 1'b1;
  assign writeNext = {addrReg[ADDR_W-1:PAGE_W], pageOff + 1'b1};
  assign commitAny = strb.commitArr | strb.commitStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strb.addrStart) begin
      addrReg <= NINE_BIT ? ADDR_W'(rxByte[3]) : '0;
    end else if (strb.addrShift) begin
      addrReg <= ADDR_W'({addrReg, rxByte});
    end else if (strb.readStep) begin
      addrReg <= readNext;
    end else if (strb.stageData) begin
      addrReg <= writeNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageMask <= '0;
    end else if (strb.addrStart || strb.commitArr) begin
      pageMask <= '0;
    end else if (strb.stageData) begin
      pageMask[pageOff] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.stageData) pageBuf[pageOff] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (strb.commitArr) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageMask[i]) mem[{addrReg[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statHold  <= '0;
      statStage <= '0;
      welR      <= 1'b0;
      busyCnt   <= '0;
    end else begin
      if (strb.stageStat) statStage <= rxByte & STAT_WR_MASK;
      if (strb.commitStat) statHold <= statStage;
      if (strb.latchClr || commitAny) welR <= 1'b0;
      else if (strb.latchSet) welR <= 1'b1;
      if (commitAny) busyCnt <= CNT_W'(WRITE_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign wip        = (busyCnt != '0);
  assign wel        = welR;
  assign statusByte = statHold | {6'b0, welR, wip};
  assign txByte     = strb.showStat ? statusByte : mem[addrReg];

endmodule

// File: rtl/spi_eeprom_target.sv
module spi_eeprom_target
  import spi_eeprom_pkg::*;
#(
  parameter int SIZE_EXP     = 2,
  parameter int PAGE_EXP     = 1,
  parameter int ADDR_BYTES   = 1,
  parameter bit NINE_BIT     = 1'b1,
  parameter int WRITE_CYCLES = 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiSelN,
  input  logic spiDin,
  output logic spiDout
);

  logic       selActive, selEnd, byteValid, wip, wel;
  logic [7:0] rxByte, txByte;
  strobe_t    strb;

  spi_eeprom_shifter #(.SYNC_STAGES(SYNC_STAGES)) uShift (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiSelN(spiSelN), .spiDin(spiDin),
    .txByte(txByte), .selActive(selActive), .selEnd(selEnd), .byteValid(byteValid),
    .rxByte(rxByte), .spiDout(spiDout)
  );

  spi_eeprom_ctrl #(.ADDR_BYTES(ADDR_BYTES), .NINE_BIT(NINE_BIT)) uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .rxByte(rxByte), .selEnd(selEnd),
    .wip(wip), .wel(wel), .strb(strb)
  );

  spi_eeprom_dp #(
    .SIZE_EXP(SIZE_EXP), .PAGE_EXP(PAGE_EXP), .NINE_BIT(NINE_BIT),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .txByte(txByte),
    .wip(wip), .wel(wel)
  );

endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk
  import spi_eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 500
) (
  input logic    clk,
  input logic    rstN,
  input logic    selActive,
  input logic    spiDout,
  input strobe_t strb,
  input logic    wip,
  input logic    wel
);

  int runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runCnt <= 0;
    else runCnt <= wip ? runCnt + 1 : 0;
  end

  AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !selActive |=> !spiDout);  // R1

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitArr || strb.commitStat) |=> (wip && !wel));  // R8

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> (runCnt == WRITE_CYCLES));  // R8

  AST_BUSY_CAP: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= WRITE_CYCLES);  // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> !(strb.latchSet || strb.latchClr || strb.addrStart || strb.stageData || strb.stageStat));  // R9

  AST_STAGE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strb.stageData |-> wel);  // R11

  AST_STATUS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strb.stageStat |-> wel);  // R10

endmodule

bind spi_eeprom_target spi_eeprom_chk #(.WRITE_CYCLES(WRITE_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .selActive(selActive), .spiDout(spiDout),
  .strb(strb), .wip(wip), .wel(wel)
);

// File: tb/spi_eeprom_target_test.sv
module spi_eeprom_target_test;

  localparam int H  = 6;
  localparam int WC = 500;

  logic clk = 1'b0;
  logic rstN, spiClk, spiSelN, spiDin;
  logic spiDout;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [512];
  logic [7:0] wbuf [32];
  logic mWel;

  always #10 clk = ~clk;

  spi_eeprom_target #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiSelN(spiSelN),
    .spiDin(spiDin), .spiDout(spiDout)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] v, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      spiDin = v[7-i];
      tick(H);
      r = {r[6:0], spiDout};
      spiClk = 1'b1;
      tick(H);
      spiClk = 1'b0;
    end
  endtask

  task automatic sel();
    spiSelN = 1'b0;
    tick(H);
  endtask

  task automatic desel();
    tick(H);
    spiSelN = 1'b1;
    tick(2 * H);
  endtask

  task automatic sendOne(input logic [7:0] op);
    logic [7:0] r;
    sel();
    xfer(op, 8, r);
    desel();
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic [7:0] r;
    sel();
    xfer(8'h05, 8, r);
    xfer(8'hFF, 8, s);
    desel();
  endtask

  task automatic wren();
    sendOne(8'h06);
    mWel = 1'b1;
  endtask

  task automatic waitReady(input string req);
    logic [7:0] s;
    int n = 0;
    readStatus(s);
    while (s[0] && n < 40) begin
      readStatus(s);
      n++;
    end
    check(!s[0], req, "busy did not clear", int'(s), 0);
  endtask

  function automatic logic [7:0] opWith(input logic [7:0] op, input logic [8:0] a);
    return op | {4'b0, a[8], 3'b0};
  endfunction

  function automatic logic [8:0] inPage(input logic [8:0] a, input int i);
    logic [3:0] off = a[3:0] + 4'(i);
    return {a[8:4], off};
  endfunction

  // write n bytes of wbuf; partial adds a trailing 3-bit fragment
  task automatic writeSeq(input logic [8:0] a, input int n, input bit partial);
    logic [7:0] r;
    sel();
    xfer(opWith(8'h02, a), 8, r);
    xfer(a[7:0], 8, r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], 8, r);
    if (partial) xfer(8'hFF, 3, r);
    desel();
    if (mWel && n > 0) begin
      for (int i = 0; i < n; i++) model[inPage(a, i)] = wbuf[i];
      mWel = 1'b0;
    end
  endtask

  task automatic readCheck(input logic [8:0] a, input int n, input string req);
    logic [7:0] r;
    logic [8:0] p;
    sel();
    xfer(opWith(8'h03, a), 8, r);
    xfer(a[7:0], 8, r);
    for (int i = 0; i < n; i++) begin
      xfer(8'hFF, 8, r);
      p = a + 9'(i);
      check(r === model[p], req, $sformatf("read byte at %0h", p), int'(r), int'(model[p]));
    end
    desel();
  endtask

  task automatic statusIs(input logic [7:0] e, input string req, input string what);
    logic [7:0] s;
    readStatus(s);
    check(s === e, req, what, int'(s), int'(e));
  endtask

  initial begin
    logic [7:0] s, r;
    logic [8:0] a;
    int n;
    void'($urandom(32'h1D5E));
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    mWel = 1'b0;
    rstN = 1'b0; spiClk = 1'b0; spiSelN = 1'b1; spiDin = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1 reset state
    check(spiDout === 1'b0, "R1", "dout while deselected", int'(spiDout), 0);
    statusIs(8'h00, "R1", "status after reset");
    readCheck(9'h000, 2, "R1");
    readCheck(9'h1F0, 2, "R1");

    // R3 latch set/clear and repeated status bytes
    wren();
    statusIs(8'h02, "R3", "status after latch set");
    sel();
    xfer(8'h05, 8, r);
    for (int i = 0; i < 3; i++) begin
      xfer(8'hFF, 8, s);
      check(s === 8'h02, "R3", "repeated status byte", int'(s), 2);
    end
    desel();

    // R2 unknown codes change nothing
    sendOne(8'h07);
    sendOne(8'hA5);
    statusIs(8'h02, "R2", "status after unknown codes");
    sendOne(8'h04);
    mWel = 1'b0;
    statusIs(8'h00, "R3", "status after latch clear");

    // R11 write with latch clear is ignored
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
    writeSeq(9'h040, 3, 1'b0);
    statusIs(8'h00, "R11", "no write cycle without latch");
    readCheck(9'h040, 3, "R11");

    // R8 / R9 timed write cycle, latch set ignored while busy
    wren();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    writeSeq(9'h105, 4, 1'b0);
    sendOne(8'h06);
    statusIs(8'h01, "R8", "busy set, latch cleared; R9 latch set ignored");
    tick(WC);
    statusIs(8'h00, "R9", "busy expired, ignored latch set stays clear");

    // R4 ninth address bit from instruction bit 3
    readCheck(9'h105, 4, "R4");
    readCheck(9'h005, 4, "R4");

    // R5 read wraps at end of array
    wren();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2;
    writeSeq(9'h1FE, 2, 1'b0);
    waitReady("R5");
    wren();
    wbuf[0] = 8'hB1; wbuf[1] = 8'hB2;
    writeSeq(9'h000, 2, 1'b0);
    waitReady("R5");
    readCheck(9'h1FE, 4, "R5");

    // R7 write wraps inside the page
    wren();
    for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h60 + i);
    writeSeq(9'h02C, 20, 1'b0);
    waitReady("R7");
    readCheck(9'h020, 16, "R7");
    readCheck(9'h030, 1, "R7");

    // R6 partial trailing byte dropped; no data means no cycle
    wren();
    wbuf[0] = 8'h77;
    writeSeq(9'h080, 1, 1'b1);
    waitReady("R6");
    readCheck(9'h080, 2, "R6");
    wren();
    writeSeq(9'h090, 0, 1'b0);
    statusIs(8'h02, "R6", "no data: no cycle, latch kept");
    readCheck(9'h090, 1, "R6");
    sendOne(8'h04);
    mWel = 1'b0;

    // R10 status write
    wren();
    sel(); xfer(8'h01, 8, r); xfer(8'hFF, 8, r); desel();
    mWel = 1'b0;
    statusIs(8'h8D, "R10", "status write starts cycle");
    waitReady("R10");
    statusIs(8'h8C, "R10", "stored protect bits");
    sel(); xfer(8'h01, 8, r); xfer(8'h00, 8, r); desel();
    statusIs(8'h8C, "R10", "status write without latch ignored");
    wren();
    sel(); xfer(8'h01, 8, r); xfer(8'h00, 8, r); desel();
    mWel = 1'b0;
    waitReady("R10");
    statusIs(8'h00, "R10", "protect bits cleared");

    // random writes, R5 and R7 read-back
    for (int k = 0; k < 12; k++) begin
      a = 9'($urandom % 512);
      n = 1 + int'($urandom % 20);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wren();
      writeSeq(a, n, 1'b0);
      waitReady("R7");
      readCheck({a[8:4], 4'h0}, 17, "R5");
    end

    summary();
    $finish;
  end

endmodule